// File: doc/BRIEF.md
# Prescaled Timer Counter with Input Capture

This block is a 16-bit up-counter whose count enable comes from a prescaler that divides the bus clock by a power of two. A small control register selects the division ratio, halts the counter and offers a self-clearing bit that zeroes both the counter and the prescaler in one write. One input-capture channel watches an external pin. On a rising edge it copies the running count into a capture register and raises a sticky flag. The channel is blind while the counter is halted.

Software reaches the block through a single-cycle register port with no handshake. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. The port has no back-pressure: every strobe is accepted in its own cycle. Four registers sit on the port.

- **Address 0, control.** Bit 0 is halt, bit 1 is the clear command, bits 4:2 are the divide select.
- **Address 1, count.** The current count, read-only.
- **Address 2, capture.** The captured count, read-only.
- **Address 3, flags.** Bit 0 is the overflow flag and bit 1 is the capture flag. Each is cleared by writing 1 to it.

Top module: `ptimer_top`

## Requirements
- R1: After reset the control register reads 0x0001 (halt=1, divide select 0), and count, capture and flags read 0. The count does not advance until halt is written to 0.
- R2: While halt is 1 the count and prescaler hold their values. After halt returns to 0, counting continues from the held values, so the total count equals the total running cycles divided by the ratio.
- R3: A control write with bit 1 set zeroes the counter and prescaler on that edge. Counting then restarts from 0x0000. The halt, divide select, capture register and flags keep their values.
- R4: The clear bit (control bit 1) always reads back 0, including right after a write that set it.
- R5: A control write with both halt and clear set leaves the count at 0x0000 and holding.
- R6: Divide select codes 0 to 6 (control bits 4:2) advance the count once every 1, 2, 4, 8, 16, 32 and 64 running cycles. After a clear, running N cycles at code s gives a count of floor(N / 2^s).
- R7: Divide select code 7 feeds no ticks and the count holds, even with halt at 0.
- R8: The count wraps from 0xFFFF to 0x0000 and sets flags bit 0. That flag stays set until a write of 1 to flags bit 0.
- R9: The capture pin passes through two synchronizing flops. A rising edge, while running, loads the count into the capture register and sets flags bit 1. That flag is cleared by writing 1 to flags bit 1.
- R10: A rising edge on the capture pin while halt is 1 is ignored. The capture register and capture flag are unchanged, and no capture happens later for that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Combinational read data |
| cap_in | input | 1 | Asynchronous input-capture pin |

## Verification
The hardest situation to reach from the ports is a capture whose expected value is exact. The count moves on every cycle, and the synchronizer adds latency. The stimulus runs the counter to a known value, then switches to divide code 7. The counter is then nominally running but frozen, so a capture edge must return exactly that value. The overflow wrap needs a full 65,536 ticks at ratio 1 from a clear. Constrained random runs with halt/resume pairs at random ratios check that the prescaler phase survives a halt.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_CAPT  = 2'd2,
    A_FLAGS = 2'd3
  } reg_addr_e;

  localparam int HALT_BIT = 0;
  localparam int CLR_BIT  = 1;
  localparam int SEL_LSB  = 2;
  localparam int SEL_W    = 3;
  localparam int OVF_BIT  = 0;
  localparam int CAPF_BIT = 1;
endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int PS_W  = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PS_W-1:0] presc;
  logic [PS_W-1:0] mask;
  logic            sel_ok;

  always_comb begin
    for (int i = 0; i < PS_W; i++) mask[i] = (i < int'(sel));
  end

  assign sel_ok = (int'(sel) <= PS_W);
  assign tick   = run && sel_ok && ((presc & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   presc <= '0;
    else if (clr) presc <= '0;
    else if (run) presc <= presc + 1'b1;
  end

  // R2
  hold_presc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(presc));
endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic at_top;
  assign at_top = &count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clr)     count <= '0;
    else if (tick)    count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf <= 1'b0;
    else if (tick && at_top && !clr) ovf <= 1'b1;
    else if (ovf_clr)                ovf <= 1'b0;
  end

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R8
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_top && !clr) |=> (ovf && count == '0));
endmodule

// File: rtl/ptimer_capture.sv
module ptimer_capture #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             run,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag
);
  logic [SYNC_N:0] sync;
  logic            rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_N-1:0], pin};
  end

  assign rise = sync[SYNC_N-1] & ~sync[SYNC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cap_val <= '0;
    else if (rise && run) cap_val <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cap_flag <= 1'b0;
    else if (rise && run) cap_flag <= 1'b1;
    else if (flag_clr)    cap_flag <= 1'b0;
  end

  // R10
  halted_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cap_val) && !$rose(cap_flag)));
  // R9
  capture_loads_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && run) |=> (cap_flag && cap_val == $past(count)));
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 6,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             cap_in
);
  localparam int CTRL_W = SEL_LSB + SEL_W;

  logic             halt;
  logic [SEL_W-1:0] sel;
  logic             ctrl_wr, flag_wr, clr_cmd, run, tick;
  logic [CNT_W-1:0] count, cap_val;
  logic             ovf, cap_flag;
  logic             unused_wr_bits;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign flag_wr = wr_en && (wr_addr == A_FLAGS);
  assign clr_cmd = ctrl_wr && wr_data[CLR_BIT];
  assign run     = !halt;
  assign unused_wr_bits = ^wr_data[CNT_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b1;
      sel  <= '0;
    end else if (ctrl_wr) begin
      halt <= wr_data[HALT_BIT];
      sel  <= wr_data[SEL_LSB +: SEL_W];
    end
  end

  ptimer_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_cmd), .sel(sel), .tick(tick)
  );

  ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_cmd),
    .ovf_clr(flag_wr && wr_data[OVF_BIT]), .count(count), .ovf(ovf)
  );

  ptimer_capture #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .run(run),
    .flag_clr(flag_wr && wr_data[CAPF_BIT]), .count(count),
    .cap_val(cap_val), .cap_flag(cap_flag)
  );

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_CTRL: begin
        rd_data[HALT_BIT]           = halt;
        rd_data[SEL_LSB +: SEL_W]   = sel;
      end
      A_COUNT: rd_data = count;
      A_CAPT:  rd_data = cap_val;
      A_FLAGS: begin
        rd_data[OVF_BIT]  = ovf;
        rd_data[CAPF_BIT] = cap_flag;
      end
      default: rd_data = '0;
    endcase
  end

  // R2
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clr_cmd) |=> $stable(count));
  // R7
  code7_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '1 && !clr_cmd) |=> $stable(count));
  // R5
  halt_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && wr_data[HALT_BIT]) |=> (count == '0 && halt));
endmodule

// File: tb/test_ptimer_top.sv
module test_ptimer_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        cap_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  ptimer_top i_ptimer_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in)
  );

  function automatic logic [15:0] ctrl_word(int sel, bit clr, bit halt);
    return 16'((sel << 2) | (int'(clr) << 1) | int'(halt));
  endfunction

  function automatic logic [15:0] exp_count(longint total, int sel);
    return 16'(total >> sel);
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // runs exactly n cycles then halts, keeping sel
  task automatic run_for(int sel, int n, bit clr);
    wr(2'd0, ctrl_word(sel, clr, 1'b0));
    repeat (n - 1) @(negedge clk);
    wr(2'd0, ctrl_word(sel, 1'b0, 1'b1));
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] held;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; cap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0001);
    rd(2'd1, v); chk("R1 count", v, 16'h0000);
    rd(2'd2, v); chk("R1 capt", v, 16'h0000);
    rd(2'd3, v); chk("R1 flags", v, 16'h0000);
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk("R1 count holds", v, 16'h0000);

    // R6 and R2: random ratios with halt/resume
    void'($urandom(32'h5eed_0042));
    for (int it = 0; it < 20; it++) begin
      int s, n, m;
      s = int'($urandom_range(0, 6));
      n = int'($urandom_range(1, 200));
      m = int'($urandom_range(1, 100));
      run_for(s, n, 1'b1);
      rd(2'd1, v); chk("R6 ratio count", v, exp_count(n, s));
      repeat (5) @(negedge clk);
      rd(2'd1, v); chk("R2 halted hold", v, exp_count(n, s));
      run_for(s, m, 1'b0);
      rd(2'd1, v); chk("R2 resume", v, exp_count(n + m, s));
    end
    // directed corner: ratio 64 exactly on the boundary
    run_for(6, 64, 1'b1);
    rd(2'd1, v); chk("R6 div64 boundary", v, 16'h0001);
    run_for(0, 1, 1'b1);
    rd(2'd1, v); chk("R6 div1 single cycle", v, 16'h0001);

    // R5 halt and clear together
    run_for(0, 10, 1'b1);
    wr(2'd0, ctrl_word(0, 1'b1, 1'b1));
    rd(2'd1, v); chk("R5 zero", v, 16'h0000);
    repeat (8) @(negedge clk);
    rd(2'd1, v); chk("R5 stays zero", v, 16'h0000);

    // R7 code 7 holds while running
    run_for(0, 37, 1'b1);
    rd(2'd1, held); chk("R7 setup", held, 16'd37);
    wr(2'd0, ctrl_word(7, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R7 no ticks", v, 16'd37);

    // R9 capture while running (frozen by code 7)
    cap_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd2, v); chk("R9 capt value", v, 16'd37);
    rd(2'd3, v); chk("R9 flag set", v, 16'h0002);
    cap_in = 1'b0;
    wr(2'd3, 16'h0002);
    rd(2'd3, v); chk("R9 flag w1c", v, 16'h0000);

    // R10 capture ignored while halted
    run_for(0, 5, 1'b1);                 // count=5, halted
    cap_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd3, v); chk("R10 no flag", v, 16'h0000);
    rd(2'd2, v); chk("R10 capt kept", v, 16'd37);
    wr(2'd0, ctrl_word(7, 1'b0, 1'b0));  // resume, pin still high
    repeat (6) @(negedge clk);
    rd(2'd3, v); chk("R10 no late capture", v, 16'h0000);
    cap_in = 1'b0;
    wr(2'd0, ctrl_word(0, 1'b0, 1'b1));

    // R8 wrap and sticky overflow
    run_for(0, 65535, 1'b1);
    rd(2'd1, v); chk("R8 at top", v, 16'hFFFF);
    rd(2'd3, v); chk("R8 no flag yet", v, 16'h0000);
    run_for(0, 1, 1'b0);
    rd(2'd1, v); chk("R8 wrapped", v, 16'h0000);
    rd(2'd3, v); chk("R8 flag set", v, 16'h0001);
    repeat (10) @(negedge clk);
    rd(2'd3, v); chk("R8 sticky", v, 16'h0001);

    // R3 clear leaves other state; R4 clear reads 0
    wr(2'd0, ctrl_word(3, 1'b0, 1'b1));
    run_for(3, 50, 1'b0);
    wr(2'd0, ctrl_word(3, 1'b1, 1'b1));
    rd(2'd1, v); chk("R3 count zero", v, 16'h0000);
    rd(2'd0, v); chk("R3 R4 ctrl kept, clear bit 0", v, 16'h000D);
    rd(2'd2, v); chk("R3 capt kept", v, 16'd37);
    rd(2'd3, v); chk("R3 ovf kept", v, 16'h0001);
    wr(2'd0, ctrl_word(2, 1'b1, 1'b0));
    rd(2'd0, v); chk("R4 clear reads 0", v, 16'h0008);
    repeat (11) @(negedge clk);
    wr(2'd0, ctrl_word(2, 1'b0, 1'b1));
    rd(2'd1, v); chk("R3 restart from zero", v, 16'd3);

    wr(2'd3, 16'h0001);
    rd(2'd3, v); chk("R8 ovf w1c", v, 16'h0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule